// File: doc/BRIEF.md
# Descriptor-chained DMA channel sequencer

This block is one DMA channel. It follows a linked list of 32-byte descriptors held in memory. Software loads a descriptor pointer, sets the enable bit and writes the doorbell register. The channel then reads the eight-word descriptor at that pointer. If the descriptor's valid flag is set, the channel copies the requested number of bytes from the source address to the destination address, one 32-bit word per read/write pair. It then optionally writes a status word and optionally clears the descriptor's valid flag in memory. After that it records the completion and moves on to the descriptor named by the descriptor's next-pointer field.

A descriptor whose valid flag is clear stops the chain, and the channel reports itself halted. A later doorbell restarts the channel at the descriptor it stopped on. Software can therefore rewrite that descriptor, make it valid and ring the doorbell again.

A single port reaches both the register file and memory. The register file is a combinational-read, single-cycle-write word port. Memory is reached through a request/acknowledge master that carries descriptor reads, data reads and writes, and status write-back.

Top module: `dchn_seq`

## Requirements
- R1: After reset every register reads zero, `mem_req` is low and `irq_o` is low. The register word indices are: 0 config (bit 0 = enable), 1 descriptor pointer, 2 status pointer, 3 doorbell, 4 interrupt flag, 5 status, 6 remaining byte count.
- R2: A write to the doorbell register while config bit 0 is clear has no effect. No memory request is made and status bit 2 stays clear.
- R3: A valid descriptor's byte count is word 1 bits 21:0. It moves ceil(count/4) words, in increasing address order, from the address in word 2 to the address in word 4. No other destination word is written, and the byte count register reads 0 afterwards.
- R4: When a fetched descriptor has word 0 bit 31 (valid) clear, no data is moved and the channel stops. Status bit 0 (halted) then reads 1. Status bit 1 shows the valid flag of the last descriptor checked.
- R5: Word 0 bits 1:0 choose the status write-back. 0 writes nothing. 1 writes the current status register value. 2 writes word 0 with bit 31 cleared. 3 writes the remaining byte count. The write goes to the status pointer when word 0 bit 4 is set, and otherwise to descriptor word 6 (offset 24).
- R6: When word 0 bit 2 is set, the channel writes word 0 back with bit 31 cleared, after the status write-back.
- R7: Interrupt register bit 0 is set by every completed descriptor. `irq_o` rises only when the completed descriptor had word 0 bit 8 set. Writing 1 to interrupt bit 0 clears both.
- R8: After a descriptor completes, the descriptor pointer register takes the value of word 7 bits 26:0 shifted left by 5, and the next fetch starts at that address.
- R9: A doorbell after a halt fetches again from the current descriptor pointer, so a descriptor that has been made valid is then processed.
- R10: A doorbell written while the channel is busy sets status bit 2 and is held. At the next descriptor found not valid, the held doorbell is consumed and that descriptor is fetched once more before the channel halts. Status bit 2 is then clear.
- R11: When a descriptor completes in the same cycle that software writes 1 to interrupt bit 0, the completion wins, and interrupt bit 0 and `irq_o` both read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge for the current request |
| irq_o | output | 1 | Interrupt line for descriptors that asked for one |

## Verification
A descriptor's completion step, which sets the interrupt flag, can land in the same clock edge as a software write-one-to-clear of that flag. The bench provokes this with a descriptor that clears its own valid flag. It watches for that clearing write to the descriptor's first word, which is always the last memory access before completion. It then places the register clear so that it is sampled on the completion edge. The flag and `irq_o` must both read 1 afterwards. A plain clear issued later must still bring both to 0.

// File: rtl/dchn_pkg.sv
// Package: shared constants, register indices, descriptor field positions,
// and the sequencer state and decoded-descriptor types for the DMA channel.
package dchn_pkg;

    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int CNT_W       = 22;
    localparam int DESC_WORDS  = 8;
    localparam int NXT_W       = 27;
    localparam int DESC_ALIGN  = 5;
    localparam int REG_IDX_W   = 3;
    localparam int CFG_W       = 10;

    // register word indices
    localparam logic [REG_IDX_W-1:0] RI_CFG  = 3'd0;
    localparam logic [REG_IDX_W-1:0] RI_DPTR = 3'd1;
    localparam logic [REG_IDX_W-1:0] RI_SPTR = 3'd2;
    localparam logic [REG_IDX_W-1:0] RI_BELL = 3'd3;
    localparam logic [REG_IDX_W-1:0] RI_IRQ  = 3'd4;
    localparam logic [REG_IDX_W-1:0] RI_STAT = 3'd5;
    localparam logic [REG_IDX_W-1:0] RI_BCNT = 3'd6;

    // descriptor word indices
    localparam int DW_CMD0 = 0;
    localparam int DW_CMD1 = 1;
    localparam int DW_SRC  = 2;
    localparam int DW_DST  = 4;
    localparam int DW_STAT = 6;
    localparam int DW_NEXT = 7;

    // command word bit positions
    localparam int C0_VALID = 31;
    localparam int C0_IE    = 8;
    localparam int C0_SPSEL = 4;
    localparam int C0_CLRV  = 2;

    typedef enum logic [1:0] {
        WB_NONE   = 2'd0,
        WB_STATUS = 2'd1,
        WB_CMD0   = 2'd2,
        WB_COUNT  = 2'd3
    } wb_sel_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CHECK, S_RD, S_WR, S_STWB, S_CLRV, S_DONE
    } seq_state_e;

    typedef struct packed {
        logic               valid;
        logic               ie;
        logic               spsel;
        logic               clrv;
        wb_sel_e            wb;
        logic [DATA_W-1:0]  cmd0_done;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  src;
        logic [ADDR_W-1:0]  dst;
        logic [ADDR_W-1:0]  next_addr;
    } desc_t;

endpackage

// File: rtl/dchn_desc.sv
// Descriptor holder: captures the words of a descriptor that the sequencer
// needs while they are fetched, and presents them decoded.
// Assumes words arrive one per capture strobe, tagged with their index.
module dchn_desc
    import dchn_pkg::*;
#(
    parameter int WORDS = DESC_WORDS,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W,
    parameter int CW    = CNT_W,
    parameter int NW    = NXT_W,
    parameter int ALIGN = DESC_ALIGN
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en,
    input  logic [$clog2(WORDS)-1:0] cap_idx,
    input  logic [DW-1:0]            cap_data,
    output desc_t                    desc
);
    localparam int IXW = $clog2(WORDS);

    logic [DW-1:0] cmd0_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] src_q;
    logic [AW-1:0] dst_q;
    logic [NW-1:0] nxt_q;

    // capture only the fields the sequencer uses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd0_q <= '0;
            cnt_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            nxt_q  <= '0;
        end else if (cap_en) begin
            if (cap_idx == IXW'(DW_CMD0)) cmd0_q <= cap_data;
            if (cap_idx == IXW'(DW_CMD1)) cnt_q  <= cap_data[CW-1:0];
            if (cap_idx == IXW'(DW_SRC))  src_q  <= cap_data;
            if (cap_idx == IXW'(DW_DST))  dst_q  <= cap_data;
            if (cap_idx == IXW'(DW_NEXT)) nxt_q  <= cap_data[NW-1:0];
        end
    end

    // field decode
    always_comb begin
        desc.valid     = cmd0_q[C0_VALID];
        desc.ie        = cmd0_q[C0_IE];
        desc.spsel     = cmd0_q[C0_SPSEL];
        desc.clrv      = cmd0_q[C0_CLRV];
        desc.wb        = wb_sel_e'(cmd0_q[1:0]);
        desc.cmd0_done = cmd0_q & ~(DW'(1) << C0_VALID);
        desc.cnt       = cnt_q;
        desc.src       = src_q;
        desc.dst       = dst_q;
        desc.next_addr = {nxt_q, {ALIGN{1'b0}}};
    end

endmodule

// File: rtl/dchn_regs.sv
// Register file of the channel: config, pointers, doorbell latch, interrupt
// flags, and the status/count read view.
// Assumes single-cycle writes; reads are combinational from the index.
module dchn_regs
    import dchn_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int CW    = CNT_W,
    parameter int IW    = REG_IDX_W,
    parameter int CFGW  = CFG_W,
    parameter int ALIGN = DESC_ALIGN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [IW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          nxt_load,
    input  logic [AW-1:0] nxt_addr,
    input  logic          done_set,
    input  logic          ie_set,
    input  logic          db_take,
    input  logic          halted,
    input  logic          dvalid,
    input  logic [CW-1:0] rem_cnt,
    output logic          ch_en,
    output logic [AW-1:0] dptr,
    output logic [AW-1:0] sptr,
    output logic          db_pend,
    output logic          irq_flag,
    output logic          irq_line
);
    logic [CFGW-1:0] cfg_q;
    logic            bell_wr;
    logic            irq_clr;

    assign bell_wr = reg_wr && (reg_addr == RI_BELL);
    assign irq_clr = reg_wr && (reg_addr == RI_IRQ) && reg_wdata[0];
    assign ch_en   = cfg_q[0];

    // config and pointer registers; the sequencer's next-pointer load wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dptr  <= '0;
            sptr  <= '0;
        end else begin
            if (reg_wr && reg_addr == RI_CFG)
                cfg_q <= reg_wdata[CFGW-1:0];
            if (nxt_load)
                dptr <= nxt_addr;
            else if (reg_wr && reg_addr == RI_DPTR)
                dptr <= {reg_wdata[AW-1:ALIGN], {ALIGN{1'b0}}};
            if (reg_wr && reg_addr == RI_SPTR)
                sptr <= {reg_wdata[AW-1:2], 2'b00};
        end
    end

    // doorbell latch: a new ring outranks consumption in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            db_pend <= 1'b0;
        else if (bell_wr && ch_en)
            db_pend <= 1'b1;
        else if (db_take)
            db_pend <= 1'b0;
    end

    // interrupt flags: completion outranks a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_flag <= 1'b0;
            irq_line <= 1'b0;
        end else begin
            if (done_set)
                irq_flag <= 1'b1;
            else if (irq_clr)
                irq_flag <= 1'b0;
            if (done_set && ie_set)
                irq_line <= 1'b1;
            else if (irq_clr)
                irq_line <= 1'b0;
        end
    end

    // read view
    always_comb begin
        unique case (reg_addr)
            RI_CFG:  reg_rdata = {{(DW-CFGW){1'b0}}, cfg_q};
            RI_DPTR: reg_rdata = dptr;
            RI_SPTR: reg_rdata = sptr;
            RI_IRQ:  reg_rdata = {{(DW-1){1'b0}}, irq_flag};
            RI_STAT: reg_rdata = {{(DW-3){1'b0}}, db_pend, dvalid, halted};
            RI_BCNT: reg_rdata = {{(DW-CW){1'b0}}, rem_cnt};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dchn_fsm.sv
// Channel sequencer: fetches a descriptor, checks its valid flag, copies
// data word by word, performs status write-back and valid clearing, then
// follows the next pointer. Drives the shared memory master port.
// Assumes the memory holds a request until it is acknowledged.
module dchn_fsm
    import dchn_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W,
    parameter int CW    = CNT_W,
    parameter int WORDS = DESC_WORDS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ch_en,
    input  logic                     db_pend,
    input  logic [AW-1:0]            dptr,
    input  logic [AW-1:0]            sptr,
    input  desc_t                    desc,
    output logic                     cap_en,
    output logic [$clog2(WORDS)-1:0] cap_idx,
    output logic                     db_take,
    output logic                     halted,
    output logic                     dvalid,
    output logic [CW-1:0]            rem_cnt,
    output logic                     done_set,
    output logic                     ie_set,
    output logic                     nxt_load,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [DW-1:0]            mem_wdata,
    input  logic [DW-1:0]            mem_rdata,
    input  logic                     mem_ack
);
    localparam int IXW  = $clog2(WORDS);
    localparam int STEP = DW / 8;
    localparam logic [IXW-1:0] LAST_IX = IXW'(WORDS - 1);

    seq_state_e     state_q;
    logic [IXW-1:0] idx_q;
    logic [CW-1:0]  cnt_q;
    logic [AW-1:0]  src_q;
    logic [AW-1:0]  dst_q;
    logic [DW-1:0]  buf_q;
    logic           halted_q;
    logic           dvalid_q;

    assign halted   = halted_q;
    assign dvalid   = dvalid_q;
    assign rem_cnt  = cnt_q;
    assign cap_en   = (state_q == S_FETCH) && mem_ack;
    assign cap_idx  = idx_q;
    assign done_set = (state_q == S_DONE);
    assign nxt_load = (state_q == S_DONE);
    assign ie_set   = desc.ie;
    assign db_take  = ((state_q == S_IDLE) && ch_en && db_pend) ||
                      ((state_q == S_CHECK) && !desc.valid && db_pend);

    // sequencer state and transfer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            idx_q    <= '0;
            cnt_q    <= '0;
            src_q    <= '0;
            dst_q    <= '0;
            buf_q    <= '0;
            halted_q <= 1'b0;
            dvalid_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (ch_en && db_pend) begin
                        state_q <= S_FETCH;
                        idx_q   <= '0;
                    end
                end
                S_FETCH: begin
                    if (mem_ack) begin
                        if (idx_q == LAST_IX) state_q <= S_CHECK;
                        else                  idx_q   <= idx_q + 1'b1;
                    end
                end
                S_CHECK: begin
                    if (!desc.valid) begin
                        dvalid_q <= 1'b0;
                        if (db_pend) begin
                            state_q <= S_FETCH;
                            idx_q   <= '0;
                        end else begin
                            halted_q <= 1'b1;
                            state_q  <= S_IDLE;
                        end
                    end else begin
                        dvalid_q <= 1'b1;
                        halted_q <= 1'b0;
                        cnt_q    <= desc.cnt;
                        src_q    <= desc.src;
                        dst_q    <= desc.dst;
                        state_q  <= (desc.cnt == '0) ? S_STWB : S_RD;
                    end
                end
                S_RD: begin
                    if (mem_ack) begin
                        buf_q   <= mem_rdata;
                        state_q <= S_WR;
                    end
                end
                S_WR: begin
                    if (mem_ack) begin
                        src_q <= src_q + AW'(STEP);
                        dst_q <= dst_q + AW'(STEP);
                        if (cnt_q <= CW'(STEP)) begin
                            cnt_q   <= '0;
                            state_q <= S_STWB;
                        end else begin
                            cnt_q   <= cnt_q - CW'(STEP);
                            state_q <= S_RD;
                        end
                    end
                end
                S_STWB: begin
                    if (desc.wb == WB_NONE || mem_ack) state_q <= S_CLRV;
                end
                S_CLRV: begin
                    if (!desc.clrv || mem_ack) state_q <= S_DONE;
                end
                S_DONE: begin
                    state_q <= S_FETCH;
                    idx_q   <= '0;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // memory master request decode
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = dptr + (AW'(idx_q) << 2);
            end
            S_RD: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            S_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = buf_q;
            end
            S_STWB: begin
                if (desc.wb != WB_NONE) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = desc.spsel ? sptr : dptr + AW'(DW_STAT * STEP);
                    unique case (desc.wb)
                        WB_STATUS: mem_wdata = {{(DW-3){1'b0}}, db_pend, dvalid_q, halted_q};
                        WB_CMD0:   mem_wdata = desc.cmd0_done;
                        WB_COUNT:  mem_wdata = {{(DW-CW){1'b0}}, cnt_q};
                        default:   mem_wdata = '0;
                    endcase
                end
            end
            S_CLRV: begin
                if (desc.clrv) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = dptr;
                    mem_wdata = desc.cmd0_done;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dchn_seq.sv
// Top of the descriptor-chained DMA channel: joins the register file, the
// descriptor holder and the sequencer. One memory master port serves
// descriptor fetch, data movement and write-back.
module dchn_seq
    import dchn_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W,
    parameter int IW = REG_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [IW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          irq_o
);
    localparam int IXW = $clog2(DESC_WORDS);

    logic           ch_en;
    logic           db_pend;
    logic           db_take;
    logic [AW-1:0]  dptr;
    logic [AW-1:0]  sptr;
    logic           halted;
    logic           dvalid;
    logic [CW-1:0]  rem_cnt;
    logic           done_set;
    logic           ie_set;
    logic           nxt_load;
    logic           irq_flag;
    logic           irq_line;
    logic           cap_en;
    logic [IXW-1:0] cap_idx;
    desc_t          desc;

    assign irq_o = irq_line;

    dchn_regs #(.AW(AW), .DW(DW), .CW(CW), .IW(IW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nxt_load(nxt_load), .nxt_addr(desc.next_addr),
        .done_set(done_set), .ie_set(ie_set), .db_take(db_take),
        .halted(halted), .dvalid(dvalid), .rem_cnt(rem_cnt),
        .ch_en(ch_en), .dptr(dptr), .sptr(sptr), .db_pend(db_pend),
        .irq_flag(irq_flag), .irq_line(irq_line)
    );

    dchn_desc #(.DW(DW), .AW(AW), .CW(CW)) u_desc (
        .clk(clk), .rst_n(rst_n),
        .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(mem_rdata),
        .desc(desc)
    );

    dchn_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ch_en(ch_en), .db_pend(db_pend), .dptr(dptr), .sptr(sptr), .desc(desc),
        .cap_en(cap_en), .cap_idx(cap_idx), .db_take(db_take),
        .halted(halted), .dvalid(dvalid), .rem_cnt(rem_cnt),
        .done_set(done_set), .ie_set(ie_set), .nxt_load(nxt_load),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

endmodule

// File: rtl/dchn_seq_chk.sv
// Checker for the DMA channel: port protocol and flag ordering properties.
// Attached to every dchn_seq instance with the bind below.
module dchn_seq_chk
    import dchn_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = REG_IDX_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [IW-1:0] reg_addr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          ch_en,
    input logic          db_pend,
    input logic          halted,
    input logic          irq_flag,
    input logic          irq_line,
    input logic          done_set
);
    // R1
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R3
    word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R2
    bell_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RI_BELL && !ch_en && !db_pend) |=> !db_pend);

    // R4
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> !mem_req);

    // R7
    line_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line |-> irq_flag);

    // R11
    done_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_set |=> irq_flag);

endmodule

bind dchn_seq dchn_seq_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .ch_en(ch_en), .db_pend(db_pend), .halted(halted),
    .irq_flag(irq_flag), .irq_line(irq_line), .done_set(done_set)
);

// File: tb/dchn_seq_test.sv
`timescale 1ns/1ps
// Directed bench for dchn_seq: one task per scenario, each checking itself.
module dchn_seq_test;

    logic        clk;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;
    logic        irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    dchn_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .irq_o(irq_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // memory model: zero-wait acknowledge, single writer process
    logic [31:0] mem [256];
    logic        clr_en;
    logic        poke_en;
    logic [7:0]  poke_idx;
    logic [31:0] poke_data;
    logic [31:0] watch_addr;
    logic [7:0]  watch_cnt;

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (clr_en) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'h0;
        end else if (poke_en) begin
            mem[poke_idx] <= poke_data;
        end else if (mem_req && mem_we) begin
            mem[mem_addr[9:2]] <= mem_wdata;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) watch_cnt <= 8'd0;
        else if (mem_req && !mem_we && mem_addr == watch_addr) watch_cnt <= watch_cnt + 8'd1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = a[9:2]; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    function automatic logic [31:0] peek(input logic [31:0] a);
        return mem[a[9:2]];
    endfunction

    task automatic wr_reg(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_addr = idx;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] c0, input logic [31:0] c1,
                            input logic [31:0] src, input logic [31:0] dst, input logic [31:0] nxt);
        poke(base,      c0);
        poke(base + 4,  c1);
        poke(base + 8,  src);
        poke(base + 12, 32'h0);
        poke(base + 16, dst);
        poke(base + 20, 32'h0);
        poke(base + 24, 32'h0000DEAD);
        poke(base + 28, nxt >> 5);
    endtask

    // wait until the memory port has been quiet for ten cycles
    task automatic wait_quiet();
        int quiet = 0;
        while (quiet < 10) begin
            @(negedge clk);
            if (mem_req) quiet = 0;
            else         quiet++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 7; i++) begin
            rd_reg(3'(i), v);
            chk($sformatf("R1 reg %0d after reset", i), v, 32'h0);
        end
        chk("R1 mem_req after reset", {31'h0, mem_req}, 32'h0);
        chk("R1 irq_o after reset", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_disabled_bell();
        logic [31:0] v;
        bit seen = 0;
        put_desc(32'h0C0, 32'h80000106, 32'd12, 32'h200, 32'h320, 32'h0C0);
        wr_reg(3'd1, 32'h0C0);
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd3, 32'h1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req) seen = 1;
        end
        chk("R2 no memory request while disabled", {31'h0, seen}, 32'h0);
        rd_reg(3'd5, v);
        chk("R2 status bit2 after disabled doorbell", v & 32'h4, 32'h0);
        chk("R2 destination untouched", peek(32'h320), 32'h0);
    endtask

    task automatic t_single();
        logic [31:0] v;
        wr_reg(3'd0, 32'h1);
        wr_reg(3'd3, 32'h1);
        wait_quiet();
        for (int i = 0; i < 3; i++)
            chk($sformatf("R3 word %0d copied", i), peek(32'h320 + 4 * i), 32'hA5000000 | i);
        chk("R3 no extra word", peek(32'h32C), 32'h0);
        rd_reg(3'd6, v);
        chk("R3 byte count register", v, 32'h0);
        chk("R5 mode 2 writes cmd0 without valid", peek(32'h0D8), 32'h00000106);
        chk("R6 valid cleared in descriptor", peek(32'h0C0), 32'h00000106);
        rd_reg(3'd5, v);
        chk("R4 halted on cleared descriptor", v, 32'h1);
        rd_reg(3'd4, v);
        chk("R7 flag after completion", v, 32'h1);
        chk("R7 irq_o with enable bit", {31'h0, irq_o}, 32'h1);
        rd_reg(3'd1, v);
        chk("R8 pointer follows self link", v, 32'h0C0);
    endtask

    task automatic t_irq_clear();
        logic [31:0] v;
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, v);
        chk("R7 flag cleared by write one", v, 32'h0);
        chk("R7 irq_o cleared", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_chain();
        logic [31:0] v;
        put_desc(32'h100, 32'h80000011, 32'd8, 32'h200, 32'h300, 32'h120);
        put_desc(32'h120, 32'h80000003, 32'd6, 32'h208, 32'h310, 32'h140);
        for (int i = 0; i < 8; i++) poke(32'h140 + 4 * i, 32'h0);
        poke(32'h3F0, 32'h0000FFFF);
        wr_reg(3'd2, 32'h3F0);
        wr_reg(3'd1, 32'h100);
        wr_reg(3'd3, 32'h1);
        wait_quiet();
        chk("R3 chain first word", peek(32'h300), 32'hA5000000);
        chk("R3 chain second word", peek(32'h304), 32'hA5000001);
        chk("R3 odd count rounds up", peek(32'h314), 32'hA5000003);
        chk("R3 nothing past rounded count", peek(32'h318), 32'h0);
        chk("R5 mode 1 status to status pointer", peek(32'h3F0), 32'h2);
        chk("R5 mode 1 leaves stat word", peek(32'h118), 32'h0000DEAD);
        chk("R5 mode 3 remaining count", peek(32'h138), 32'h0);
        rd_reg(3'd1, v);
        chk("R8 pointer after chain", v, 32'h140);
        rd_reg(3'd5, v);
        chk("R4 halted with valid bit low", v, 32'h1);
        rd_reg(3'd4, v);
        chk("R7 flag set without enable bit", v, 32'h1);
        chk("R7 irq_o stays low without enable bit", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        put_desc(32'h140, 32'h80000000, 32'd4, 32'h210, 32'h380, 32'h160);
        for (int i = 0; i < 8; i++) poke(32'h160 + 4 * i, 32'h0);
        wr_reg(3'd3, 32'h1);
        wait_quiet();
        chk("R9 restarted descriptor moved data", peek(32'h380), 32'hA5000004);
        rd_reg(3'd1, v);
        chk("R9 pointer moved on after restart", v, 32'h160);
        rd_reg(3'd5, v);
        chk("R9 halted again at end", v, 32'h1);
    endtask

    task automatic t_busy_bell();
        logic [31:0] v;
        logic [7:0]  c0;
        put_desc(32'h180, 32'h80000000, 32'd32, 32'h200, 32'h3A0, 32'h1A0);
        for (int i = 0; i < 8; i++) poke(32'h1A0 + 4 * i, 32'h0);
        @(negedge clk);
        watch_addr = 32'h1A0;
        @(negedge clk);
        c0 = watch_cnt;
        wr_reg(3'd1, 32'h180);
        wr_reg(3'd3, 32'h1);
        repeat (12) @(negedge clk);
        wr_reg(3'd3, 32'h1);
        rd_reg(3'd5, v);
        chk("R10 status bit2 while busy", v & 32'h4, 32'h4);
        wait_quiet();
        chk("R10 invalid descriptor fetched twice", {24'h0, watch_cnt - c0}, 32'd2);
        rd_reg(3'd5, v);
        chk("R10 doorbell consumed and halted", v, 32'h1);
        chk("R3 last word of long copy", peek(32'h3BC), 32'hA5000007);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        int guard = 0;
        wr_reg(3'd4, 32'h1);
        put_desc(32'h1C0, 32'h80000104, 32'd4, 32'h200, 32'h340, 32'h1C0);
        wr_reg(3'd1, 32'h1C0);
        wr_reg(3'd3, 32'h1);
        // wait for the valid-clearing write, the last access before completion
        do begin
            @(negedge clk);
            guard++;
        end while (!(mem_req && mem_we && mem_addr == 32'h1C0) && guard < 200);
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        rd_reg(3'd4, v);
        chk("R11 completion beats same-cycle clear", v, 32'h1);
        chk("R11 irq_o kept", {31'h0, irq_o}, 32'h1);
        wait_quiet();
        chk("R5 mode 0 leaves stat word", peek(32'h1D8), 32'h0000DEAD);
        chk("R3 single word copy", peek(32'h340), 32'hA5000000);
        wr_reg(3'd4, 32'h1);
        rd_reg(3'd4, v);
        chk("R7 later clear works", v, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 32'h0;
        poke_en = 1'b0; poke_idx = 8'h0; poke_data = 32'h0; clr_en = 1'b1;
        watch_addr = 32'hFFFFFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        clr_en = 1'b0;
        rst_n  = 1'b1;
        t_reset();
        for (int i = 0; i < 16; i++) poke(32'h200 + 4 * i, 32'hA5000000 | i);
        t_disabled_bell();
        t_single();
        t_irq_clear();
        t_chain();
        t_restart();
        t_busy_bell();
        t_collision();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule